// File: doc/BRIEF.md
# Prioritized Interrupt Sense Unit

This block gathers five interrupt requests for a small 8-bit processor core and picks at most one of them at each instruction boundary. The sources are a non-maskable request, an edge-latched maskable request, two level-sensitive maskable requests, and a general request. The general request is vectored by an opcode that an external device supplies during an acknowledge cycle. The unit holds a global enable flag and a three-bit mask register. It looks at the requests only when the core raises its sampling strobe. The core asserts that strobe in the next-to-last clock of an instruction's final machine cycle.

When a source is accepted, the unit pulses `take_o` for one cycle and reports the source code. For fixed sources it presents the restart address in the same cycle. For the general request it runs a three-state acknowledge cycle. The acknowledge strobe is low in the second state, and the supplied opcode is captured at the end of that state. The unit then presents the derived restart address in the third state.

Top module: `intr_sense_unit`

## Requirements
- R1: A source is accepted only at a clock edge where `sample_i` is 1 and no acknowledge cycle is running. `take_o` is 1 for exactly the following cycle. `src_o` is 0 in every cycle without `take_o`.
- R2: A rising edge on `edge_req_i` sets a pending latch even when the request is masked, so a one-cycle pulse is enough. The latch is cleared when that source is accepted, or by a mask write with `mask_d_i[3]`=1. If an edge and a clear arrive in the same cycle, the latch is set.
- R3: Fixed priority, highest first: non-maskable (code 1), edge request (code 2), high level request (code 3), low level request (code 4), general request (code 5). Code 0 means none.
- R4: Maskable sources are recognised only while the enable flag is 1. The edge and level sources also need their mask bit to be 0: bit 2 for the edge request, bit 1 for the high level request, bit 0 for the low level request. A mask write loads bits 2:0 from `mask_d_i`.
- R5: The level requests and the non-maskable request are seen only if they are 1 at the sampling edge. A level request that drops before that edge is lost.
- R6: `ei_i` sets the enable flag. Any acceptance clears it, and the clear wins over an `ei_i` in the same cycle.
- R7: The non-maskable request is accepted whenever it is sampled, regardless of the enable flag and the masks.
- R8: The restart address, valid with `vec_valid_o` in the `take_o` cycle, is 0x0024 for code 1, 0x003C for code 2, 0x0034 for code 3 and 0x002C for code 4.
- R9: On acceptance of code 5, `ack_req_o` is 1 for three cycles (T1, T2, T3). `inta_no` is 0 only in T2, and `opcode_i` is captured at the end of T2. In T3, `vec_valid_o` is 1 and `vec_o` = `opcode_i[5:3]`×8. `sample_i` is ignored while `ack_req_o` is 1.
- R10: Reset clears the enable flag and the edge latch, and sets all three mask bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | Instruction sampling-point strobe |
| ei_i | input | 1 | Enable-interrupts command |
| mask_wr_i | input | 1 | Mask write command |
| mask_d_i | input | 4 | Bits 2:0 mask values, bit 3 clears the edge latch |
| nmi_i | input | 1 | Non-maskable request |
| edge_req_i | input | 1 | Edge-latched maskable request |
| lvl_hi_i | input | 1 | Higher level-sensitive request |
| lvl_lo_i | input | 1 | Lower level-sensitive request |
| gen_req_i | input | 1 | General request, vectored by acknowledge |
| opcode_i | input | 8 | Opcode supplied during acknowledge T2 |
| take_o | output | 1 | Acceptance pulse |
| src_o | output | 3 | Accepted source code |
| vec_o | output | 16 | Restart address |
| vec_valid_o | output | 1 | Restart address valid |
| ack_req_o | output | 1 | Acknowledge cycle in progress |
| inta_no | output | 1 | Acknowledge strobe, active low |

## Verification
The assertions assume that the core never raises `sample_i` during an acknowledge cycle in a way that must be honoured, and that the opcode is stable at the T2 edge. The acknowledge assertions also assume the requests are synchronous to `clk_i`. The bench changes every input half a cycle away from the active edge. It presents the opcode only in T2. It starts each sweep case from reset, so the enable flag and the latch begin from known values. One directed case deliberately pulses `sample_i` during T2 to show that it is ignored.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int N_SRC  = 5;
  localparam int N_MASK = 3;
  localparam int VEC_W  = 16;
  localparam int OP_W   = 8;

  typedef enum logic [2:0] {
    SRC_NONE   = 3'd0,
    SRC_NMI    = 3'd1,
    SRC_EDGE   = 3'd2,
    SRC_LVL_HI = 3'd3,
    SRC_LVL_LO = 3'd4,
    SRC_GEN    = 3'd5
  } src_t;

  localparam logic [VEC_W-1:0] VEC_NMI    = 16'h0024;
  localparam logic [VEC_W-1:0] VEC_EDGE   = 16'h003C;
  localparam logic [VEC_W-1:0] VEC_LVL_HI = 16'h0034;
  localparam logic [VEC_W-1:0] VEC_LVL_LO = 16'h002C;

  function automatic logic [VEC_W-1:0] fixed_vec(src_t s);
    case (s)
      SRC_NMI:    return VEC_NMI;
      SRC_EDGE:   return VEC_EDGE;
      SRC_LVL_HI: return VEC_LVL_HI;
      SRC_LVL_LO: return VEC_LVL_LO;
      default:    return '0;
    endcase
  endfunction
endpackage

// File: rtl/intr_edge_latch.sv
module intr_edge_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pin_q;
  logic rise;

  assign rise = pin_i & ~pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q  <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      pin_q <= pin_i;
      if (rise)       pend_o <= 1'b1;  // new edge beats a clear
      else if (clr_i) pend_o <= 1'b0;
    end
  end

  p_edge_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pin_i) |=> pend_o);
  p_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !pin_i) |=> !pend_o);
endmodule

// File: rtl/intr_prio_arb.sv
module intr_prio_arb
  import intr_pkg::*;
(
  input  logic              nmi_i,
  input  logic              pend_edge_i,
  input  logic              lvl_hi_i,
  input  logic              lvl_lo_i,
  input  logic              gen_i,
  input  logic              ie_i,
  input  logic [N_MASK-1:0] mask_i,
  output src_t              win_o
);
  logic [N_MASK-1:0] raw_m;
  logic [N_MASK-1:0] gated;
  logic [N_SRC-1:0]  req;   // index 0 = highest priority

  assign raw_m = {pend_edge_i, lvl_hi_i, lvl_lo_i};

  for (genvar g = 0; g < N_MASK; g++) begin : g_lane
    assign gated[g] = ie_i & raw_m[g] & ~mask_i[g];
  end

  assign req = {ie_i & gen_i, gated[0], gated[1], gated[2], nmi_i};

  always_comb begin
    win_o = SRC_NONE;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req[i]) win_o = src_t'(3'(i + 1));
    end
  end
endmodule

// File: rtl/intr_ack_seq.sv
module intr_ack_seq
  import intr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [OP_W-1:0]  opcode_i,
  output logic             busy_o,
  output logic             inta_no,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_valid_o
);
  typedef enum logic [1:0] {S_IDLE, S_T1, S_T2, S_T3} st_t;
  st_t st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      vec_o <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (start_i) st_q <= S_T1;
        S_T1:   st_q <= S_T2;
        S_T2: begin
          st_q  <= S_T3;
          vec_o <= VEC_W'({opcode_i[5:3], 3'b000});
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != S_IDLE);
  assign inta_no     = (st_q != S_T2);
  assign vec_valid_o = (st_q == S_T3);

  p_strobe_in_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inta_no |-> busy_o);
  p_strobe_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inta_no |=> (inta_no && vec_valid_o));
  p_start_t1_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && inta_no && !vec_valid_o));
endmodule

// File: rtl/intr_sense_unit.sv
module intr_sense_unit
  import intr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              ei_i,
  input  logic              mask_wr_i,
  input  logic [N_MASK:0]   mask_d_i,
  input  logic              nmi_i,
  input  logic              edge_req_i,
  input  logic              lvl_hi_i,
  input  logic              lvl_lo_i,
  input  logic              gen_req_i,
  input  logic [OP_W-1:0]   opcode_i,
  output logic              take_o,
  output logic [2:0]        src_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              vec_valid_o,
  output logic              ack_req_o,
  output logic              inta_no
);
  logic              ie_q;
  logic [N_MASK-1:0] mask_q;
  logic              pend_edge;
  logic              edge_clr;
  logic              accept;
  src_t              win;
  src_t              src_q;
  logic              take_q;
  logic [VEC_W-1:0]  fix_vec_q;
  logic              fix_valid_q;
  logic [VEC_W-1:0]  ack_vec;
  logic              ack_valid;
  logic              ack_busy;

  assign accept   = sample_i & ~ack_busy & (win != SRC_NONE);
  assign edge_clr = (mask_wr_i & mask_d_i[N_MASK]) | (accept & (win == SRC_EDGE));

  intr_edge_latch u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (edge_req_i),
    .clr_i  (edge_clr),
    .pend_o (pend_edge)
  );

  intr_prio_arb u_arb (
    .nmi_i       (nmi_i),
    .pend_edge_i (pend_edge),
    .lvl_hi_i    (lvl_hi_i),
    .lvl_lo_i    (lvl_lo_i),
    .gen_i       (gen_req_i),
    .ie_i        (ie_q),
    .mask_i      (mask_q),
    .win_o       (win)
  );

  intr_ack_seq u_ack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept & (win == SRC_GEN)),
    .opcode_i    (opcode_i),
    .busy_o      (ack_busy),
    .inta_no     (inta_no),
    .vec_o       (ack_vec),
    .vec_valid_o (ack_valid)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q        <= 1'b0;
      mask_q      <= '1;
      take_q      <= 1'b0;
      src_q       <= SRC_NONE;
      fix_vec_q   <= '0;
      fix_valid_q <= 1'b0;
    end else begin
      if (accept)    ie_q <= 1'b0;
      else if (ei_i) ie_q <= 1'b1;
      if (mask_wr_i) mask_q <= mask_d_i[N_MASK-1:0];
      take_q      <= accept;
      src_q       <= accept ? win : SRC_NONE;
      fix_vec_q   <= fixed_vec(win);
      fix_valid_q <= accept & (win != SRC_GEN);
    end
  end

  assign take_o      = take_q;
  assign src_o       = src_q;
  assign ack_req_o   = ack_busy;
  assign vec_valid_o = fix_valid_q | ack_valid;
  assign vec_o       = ack_valid ? ack_vec : fix_vec_q;

  p_take_needs_sample_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $past(sample_i));
  p_ie_cleared_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> !ie_q);
  p_mask_hi_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && src_o == SRC_LVL_HI) |-> $past(ie_q && !mask_q[1]));
  p_nmi_always_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && nmi_i && !ack_req_o) |=> (take_o && src_o == SRC_NMI));
  p_nmi_vec_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && src_o == SRC_NMI) |-> (vec_valid_o && vec_o == VEC_NMI));
  p_gen_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && src_o == SRC_GEN) |-> (ack_req_o && inta_no && !vec_valid_o));
endmodule

// File: tb/intr_sense_unit_tb.sv
module intr_sense_unit_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sample_i = 0, ei_i = 0, mask_wr_i = 0;
  logic [3:0] mask_d_i = '0;
  logic nmi_i = 0, edge_req_i = 0, lvl_hi_i = 0, lvl_lo_i = 0, gen_req_i = 0;
  logic [7:0] opcode_i = '0;
  logic take_o, vec_valid_o, ack_req_o, inta_no;
  logic [2:0] src_o;
  logic [15:0] vec_o;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  intr_sense_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sample_i(sample_i), .ei_i(ei_i),
    .mask_wr_i(mask_wr_i), .mask_d_i(mask_d_i), .nmi_i(nmi_i),
    .edge_req_i(edge_req_i), .lvl_hi_i(lvl_hi_i), .lvl_lo_i(lvl_lo_i),
    .gen_req_i(gen_req_i), .opcode_i(opcode_i), .take_o(take_o),
    .src_o(src_o), .vec_o(vec_o), .vec_valid_o(vec_valid_o),
    .ack_req_o(ack_req_o), .inta_no(inta_no)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; sample_i = 0; ei_i = 0; mask_wr_i = 0; mask_d_i = '0;
    nmi_i = 0; edge_req_i = 0; lvl_hi_i = 0; lvl_lo_i = 0; gen_req_i = 0;
    step(); step();
    rst_ni = 1'b1;
    step();
  endtask

  task automatic wr_mask(input logic [3:0] d);
    mask_wr_i = 1; mask_d_i = d; step(); mask_wr_i = 0;
  endtask

  task automatic pulse_ei();
    ei_i = 1; step(); ei_i = 0;
  endtask

  task automatic pulse_edge();
    edge_req_i = 1; step(); edge_req_i = 0;
  endtask

  function automatic int exp_src(bit n, bit p, bit h, bit l, bit g, bit ie, logic [2:0] m);
    if (n) return 1;
    if (ie && p && !m[2]) return 2;
    if (ie && h && !m[1]) return 3;
    if (ie && l && !m[0]) return 4;
    if (ie && g) return 5;
    return 0;
  endfunction

  function automatic int exp_vec(int s);
    case (s)
      1: return 'h24;
      2: return 'h3C;
      3: return 'h34;
      4: return 'h2C;
      default: return 0;
    endcase
  endfunction

  // raise sample for one edge and check the result; runs the ack cycle for code 5
  task automatic sample_check(input int es, input logic [7:0] op);
    sample_i = 1; step(); sample_i = 0;
    chk(take_o == (es != 0), "R1 take", take_o, es != 0);
    chk(src_o == es[2:0], "R3 src", src_o, es);
    if (es != 0 && es != 5)
      chk(vec_valid_o && vec_o == exp_vec(es), "R8 vector", vec_o, exp_vec(es));
    if (es == 5) begin
      chk(ack_req_o && inta_no && !vec_valid_o, "R9 T1", {ack_req_o, inta_no}, 3);
      step();
      chk(ack_req_o && !inta_no, "R9 T2 strobe", {ack_req_o, inta_no}, 2);
      opcode_i = op;
      step();
      opcode_i = 8'h00;
      chk(ack_req_o && inta_no && vec_valid_o && vec_o == int'(op[5:3]) * 8,
          "R9 T3 vector", vec_o, int'(op[5:3]) * 8);
      step();
      chk(!ack_req_o && !vec_valid_o, "R9 end", ack_req_o, 0);
    end
  endtask

  initial begin
    #2_000_000ns;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    step();
    // R10: after reset, all maskables pending but ie=0 and masked
    do_reset();
    chk(!take_o && !ack_req_o && inta_no && !vec_valid_o, "R10 idle outputs", take_o, 0);
    pulse_edge();
    lvl_hi_i = 1; lvl_lo_i = 1; gen_req_i = 1;
    sample_check(0, 8'h00);
    // R10: only ei given, masks still set -> general request wins
    pulse_ei();
    sample_check(5, 8'hCF);
    lvl_hi_i = 0; lvl_lo_i = 0; gen_req_i = 0;

    // R1: no acceptance without sample strobe
    do_reset(); wr_mask(4'h0); pulse_ei();
    lvl_hi_i = 1;
    for (int i = 0; i < 4; i++) begin
      step();
      chk(!take_o && src_o == 0, "R1 no sample", take_o, 0);
    end
    lvl_hi_i = 0;

    // R5: level request dropped before sampling is lost
    lvl_lo_i = 1; step(); lvl_lo_i = 0;
    sample_check(0, 8'h00);

    // R2: latch clear bit in mask write
    do_reset(); wr_mask(4'h0); pulse_ei(); pulse_edge();
    wr_mask(4'h8);
    sample_check(0, 8'h00);
    // R2: edge latched while masked, recognised once unmasked
    do_reset(); wr_mask(4'h4); pulse_ei(); pulse_edge();
    wr_mask(4'h0);
    sample_check(2, 8'h00);

    // R6: accept wins over simultaneous ei
    do_reset(); wr_mask(4'h0); pulse_ei();
    lvl_hi_i = 1; ei_i = 1;
    sample_check(3, 8'h00);
    ei_i = 0;
    sample_check(0, 8'h00);
    lvl_hi_i = 0;

    // R9: sample ignored during ack cycle
    do_reset(); pulse_ei();
    gen_req_i = 1;
    sample_i = 1; step(); sample_i = 0;
    chk(take_o && src_o == 5, "R9 gen take", src_o, 5);
    step();
    nmi_i = 1; sample_i = 1; opcode_i = 8'hD7; step(); sample_i = 0; nmi_i = 0;
    chk(!take_o && vec_valid_o && vec_o == 16'h0010, "R9 ignore sample", {take_o, vec_o}, 16'h0010);
    step();
    chk(!take_o, "R9 ignore sample after", take_o, 0);
    gen_req_i = 0;

    // sweep: pins x enable x mask (R3 R4 R7 R8 R2 R6)
    for (int c = 0; c < 512; c++) begin
      bit n, e, h, l, g, ie;
      logic [2:0] m;
      int s1, s2;
      {g, l, h, e, n} = c[4:0];
      ie = c[5];
      m  = c[8:6];
      do_reset();
      wr_mask({1'b0, m});
      if (ie) pulse_ei();
      if (e) pulse_edge();
      nmi_i = n; lvl_hi_i = h; lvl_lo_i = l; gen_req_i = g;
      s1 = exp_src(n, e, h, l, g, ie, m);
      sample_check(s1, 8'hC7 | 8'((c % 8) << 3));
      // R6/R2 second sample: ie cleared and edge latch consumed after an acceptance
      s2 = (s1 == 0) ? 0 : exp_src(n, (s1 == 2) ? 1'b0 : e, h, l, g, 1'b0, m);
      sample_check(s2, 8'h00);
      nmi_i = 0; lvl_hi_i = 0; lvl_lo_i = 0; gen_req_i = 0;
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule